// File: doc/BRIEF.md
# Alternating-Reload PWM Generator

This block drives the gate of a buck converter's high-side switch with a fixed-frequency pulse train. It does not compare a free-running ramp against a threshold. A single down-counting timer is loaded with the high-phase length, and when that count runs out it is loaded with the low-phase length. The output level flips each time the timer runs out. The timer advances on a tick obtained by dividing the system clock by a fixed ratio. With the default division of 12 and a default period of 550 ticks, a 33 MHz clock gives a 5 kHz switching frequency.

Duty is commanded by an 8-bit error code that arrives with a one-cycle sample strobe. The code is scaled to a high-phase tick count and clamped to configurable limits. The low-phase count is the rest of the period. The pair is captured into shadow storage on the strobe. It moves into the active registers only when a new period begins, so a period never mixes two commands. The block produces no output until the first command arrives after reset.

Top module: `pwm_reload_gen`

## Requirements
- R1: After synchronous reset, `pwm_out`, `load_pulse`, `on_cnt` and `off_cnt` are all zero. `pwm_out` stays low for as long as no strobe has been received.
- R2: An error code E maps to a high count H = floor(E * PERIOD / 255), limited by R3. The low count is PERIOD - H, so the two counts always add up to PERIOD.
- R3: H is clamped into [ON_MIN, ON_MAX]. A code that scales below ON_MIN yields ON_MIN, and a code that scales above ON_MAX yields ON_MAX. The command never wraps.
- R4: In every period, `pwm_out` is high for H*PRESCALE clock cycles and then low for (PERIOD-H)*PRESCALE clock cycles. A high level means the high-side switch is on.
- R5: The timer advances once every PRESCALE clock cycles (default 12), and `pwm_out` changes only on such a tick. The default PERIOD is 550 ticks.
- R6: A strobe only fills the shadow storage. The running period and the `on_cnt`/`off_cnt` outputs keep their old values until the next period start.
- R7: A period starts at a tick where the low phase ends, or where the high phase ends with a zero low count. If a command is pending at that tick, `load_pulse` is high for exactly that one cycle, and `on_cnt`/`off_cnt` show the new pair from that same cycle.
- R8: With H = 0, `pwm_out` stays low through the whole period, with no one-tick high pulse.
- R9: With H = PERIOD, `pwm_out` stays high continuously across period starts, with no one-tick low pulse.
- R10: If a strobe falls in the same cycle as a period start, that period uses the command that was already pending. The newly strobed command waits for the following period start.
- R11: The first strobe after reset starts the first period at the next prescaler tick, which comes within PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| err_in | input | ERR_W | Digitized error code |
| err_valid | input | 1 | One-cycle sample strobe for `err_in` |
| pwm_out | output | 1 | Gate command, high = high-side switch on |
| on_cnt | output | CNT_W | Active high-phase length in ticks |
| off_cnt | output | CNT_W | Active low-phase length in ticks |
| load_pulse | output | 1 | One-cycle flag: shadow pair moved to active |

## Verification
The sample strobe and the period-start tick are independent paths, and they can land in the same clock cycle. The bench first starts a period, then places one strobe mid-period so that a command is pending. It then counts exactly one period length from the observed rising edge and drives a second strobe in the cycle of the next boundary. The result is judged at the ports. At the boundary, `load_pulse` must rise together with `on_cnt` showing the earlier pending command, and the high span that follows must match that command. The later command must appear only at the next boundary.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;
endpackage

// File: rtl/pwmgen_prescaler.sv
module pwmgen_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == PW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R5: no tick in the cycle right after another unless division is one
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/pwmgen_duty_map.sv
module pwmgen_duty_map #(
    parameter int ERR_W  = 8,
    parameter int PERIOD = 550,
    parameter int CNT_W  = 10,
    parameter int ON_MIN = 0,
    parameter int ON_MAX = 550
) (
    input  logic [ERR_W-1:0] err,
    output logic [CNT_W-1:0] on_ticks,
    output logic [CNT_W-1:0] off_ticks
);
    localparam int PW   = ERR_W + CNT_W;
    localparam int FULL = (1 << ERR_W) - 1;

    logic [PW-1:0] prod, raw, lo_clip, hi_clip;

    assign prod = PW'(err) * PW'(PERIOD);
    assign raw  = prod / PW'(FULL);

    generate
        if (ON_MIN > 0) begin : g_lo_clamp
            assign lo_clip = (raw < PW'(ON_MIN)) ? PW'(ON_MIN) : raw;
        end else begin : g_lo_pass
            assign lo_clip = raw;
        end
    endgenerate

    assign hi_clip   = (lo_clip > PW'(ON_MAX)) ? PW'(ON_MAX) : lo_clip;
    assign on_ticks  = CNT_W'(hi_clip);
    assign off_ticks = CNT_W'(PERIOD) - on_ticks;
endmodule

// File: rtl/pwmgen_shadow.sv
module pwmgen_shadow #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             take,
    input  logic [CNT_W-1:0] on_in,
    input  logic [CNT_W-1:0] off_in,
    output logic [CNT_W-1:0] shd_on,
    output logic [CNT_W-1:0] shd_off,
    output logic             pend
);
    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] on_t;
        logic [CNT_W-1:0] off_t;
    } shd_t;

    shd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (strobe) begin
            s_d.on_t  = on_in;
            s_d.off_t = off_in;
            s_d.pend  = 1'b1;
        end else if (take) begin
            s_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign shd_on  = s_q.on_t;
    assign shd_off = s_q.off_t;
    assign pend    = s_q.pend;

    // R10: a strobe in the same cycle as a transfer leaves a command pending
    assert_strobe_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && take) |=> pend);
endmodule

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen #(
    parameter int ERR_W    = 8,
    parameter int PRESCALE = 12,
    parameter int PERIOD   = 550,
    parameter int ON_MIN   = 0,
    parameter int ON_MAX   = PERIOD,
    localparam int CNT_W   = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] err_in,
    input  logic             err_valid,
    output logic             pwm_out,
    output logic [CNT_W-1:0] on_cnt,
    output logic [CNT_W-1:0] off_cnt,
    output logic             load_pulse
);
    import pwmgen_pkg::*;

    typedef struct packed {
        logic             running;
        phase_e           phase;
        logic             pwm;
        logic             load;
        logic [CNT_W-1:0] timer;
        logic [CNT_W-1:0] act_on;
        logic [CNT_W-1:0] act_off;
    } gen_t;

    gen_t g_d, g_q;

    logic             tick;
    logic [CNT_W-1:0] map_on, map_off;
    logic [CNT_W-1:0] shd_on, shd_off;
    logic             pend;
    logic             take;
    logic             start;
    logic [CNT_W-1:0] sel_on, sel_off;

    pwmgen_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pwmgen_duty_map #(
        .ERR_W  (ERR_W),
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W),
        .ON_MIN (ON_MIN),
        .ON_MAX (ON_MAX)
    ) u_map (
        .err       (err_in),
        .on_ticks  (map_on),
        .off_ticks (map_off)
    );

    pwmgen_shadow #(.CNT_W(CNT_W)) u_shd (
        .clk     (clk),
        .rst     (rst),
        .strobe  (err_valid),
        .take    (take),
        .on_in   (map_on),
        .off_in  (map_off),
        .shd_on  (shd_on),
        .shd_off (shd_off),
        .pend    (pend)
    );

    always_comb begin
        g_d      = g_q;
        g_d.load = 1'b0;
        start    = 1'b0;
        take     = 1'b0;
        sel_on   = pend ? shd_on  : g_q.act_on;
        sel_off  = pend ? shd_off : g_q.act_off;

        if (tick) begin
            if (!g_q.running) begin
                start = pend;
            end else if (g_q.timer > CNT_W'(1)) begin
                g_d.timer = g_q.timer - CNT_W'(1);
            end else if (g_q.phase == PH_HIGH && g_q.act_off != '0) begin
                g_d.phase = PH_LOW;
                g_d.pwm   = 1'b0;
                g_d.timer = g_q.act_off;
            end else begin
                start = 1'b1;
            end

            if (start) begin
                take        = pend;
                g_d.load    = pend;
                g_d.running = 1'b1;
                g_d.act_on  = sel_on;
                g_d.act_off = sel_off;
                if (sel_on != '0) begin
                    g_d.phase = PH_HIGH;
                    g_d.pwm   = 1'b1;
                    g_d.timer = sel_on;
                end else begin
                    g_d.phase = PH_LOW;
                    g_d.pwm   = 1'b0;
                    g_d.timer = sel_off;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    assign pwm_out    = g_q.pwm;
    assign on_cnt     = g_q.act_on;
    assign off_cnt    = g_q.act_off;
    assign load_pulse = g_q.load;

    // R1: quiet until the first command has started a period
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !g_q.running |-> (!pwm_out && on_cnt == '0 && off_cnt == '0));

    // R2: active pair always covers the full period
    assert_sum_period_R2: assert property (@(posedge clk) disable iff (rst)
        g_q.running |-> ({1'b0, on_cnt} + {1'b0, off_cnt}) == (CNT_W+1)'(PERIOD));

    // R3: active high count never exceeds the upper limit
    assert_clamp_hi_R3: assert property (@(posedge clk) disable iff (rst)
        g_q.running |-> on_cnt <= CNT_W'(ON_MAX));

    // R5: output level moves only on a prescaler tick
    assert_edge_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (pwm_out != $past(pwm_out)) |-> $past(tick));

    // R6: active counts change only together with a load
    assert_hold_active_R6: assert property (@(posedge clk) disable iff (rst)
        (on_cnt != $past(on_cnt) || off_cnt != $past(off_cnt)) |-> load_pulse);

    // R7: a load is produced by a tick
    assert_load_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $past(tick));

    // R8: zero high count keeps the gate off
    assert_zero_on_R8: assert property (@(posedge clk) disable iff (rst)
        (g_q.running && on_cnt == '0) |-> !pwm_out);

    // R9: zero low count keeps the gate on
    assert_zero_off_R9: assert property (@(posedge clk) disable iff (rst)
        (g_q.running && off_cnt == '0) |-> pwm_out);
endmodule

// File: tb/pwm_reload_gen_tb.sv
module pwm_reload_gen_tb;
    localparam int P  = 3;
    localparam int N  = 40;
    localparam int CW = $clog2(N + 1);
    localparam int LMIN = 4;
    localparam int LMAX = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    err_in = '0;
    logic          err_valid = 1'b0;
    logic          pwm, pwm_l;
    logic [CW-1:0] on_c, off_c, on_l, off_l;
    logic          ld, ld_l;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_reload_gen #(.ERR_W(8), .PRESCALE(P), .PERIOD(N)) u_dut (
        .clk(clk), .rst(rst), .err_in(err_in), .err_valid(err_valid),
        .pwm_out(pwm), .on_cnt(on_c), .off_cnt(off_c), .load_pulse(ld));

    pwm_reload_gen #(.ERR_W(8), .PRESCALE(P), .PERIOD(N),
                     .ON_MIN(LMIN), .ON_MAX(LMAX)) u_dut_lim (
        .clk(clk), .rst(rst), .err_in(err_in), .err_valid(err_valid),
        .pwm_out(pwm_l), .on_cnt(on_l), .off_cnt(off_l), .load_pulse(ld_l));

    function automatic int map_on(input int e, input int lo, input int hi);
        int r = (e * N) / 255;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int e);
        @(negedge clk);
        err_in    = 8'(e);
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic wait_load(output int waited);
        waited = 0;
        while (!ld && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (!ld) chk("R7 load timeout", 0, 1);
    endtask

    task automatic wait_rise();
        logic prev;
        int   n = 0;
        prev = pwm;
        @(negedge clk);
        while (!(pwm && !prev) && n < 2000) begin
            prev = pwm;
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk("R4 rise timeout", 0, 1);
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        hi = 0;
        while (pwm && hi < 2000) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm && lo < 2000) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int highs = 0;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk("R1 pwm after reset", pwm, 0);
        chk("R1 on_cnt after reset", on_c, 0);
        chk("R1 off_cnt after reset", off_c, 0);
        chk("R1 load after reset", ld, 0);
        repeat (200) begin @(negedge clk); if (pwm) highs++; end
        chk("R1 no output without strobe", highs, 0);
    endtask

    task automatic t_first();
        int w, hi, lo;
        strobe(128);
        wait_load(w);
        checks++;
        if (w > P) begin
            fails++;
            $display("FAIL R11 first load latency actual=%0d expected<=%0d", w, P);
        end
        chk("R7 load with rise", pwm, 1);
        chk("R2 on 128", on_c, 20);
        chk("R2 off 128", off_c, 20);
        chk("R3 lim on 128", on_l, 20);
        measure(hi, lo);
        chk("R4 high 128", hi, 20 * P);
        chk("R5 period clocks", hi + lo, N * P);
    endtask

    task automatic t_values();
        int vals[3] = '{64, 200, 10};
        int w, hi, lo, e;
        for (int i = 0; i < 3; i++) begin
            e = vals[i];
            strobe(e);
            wait_load(w);
            chk("R2 on count", on_c, map_on(e, 0, N));
            chk("R2 off count", off_c, N - map_on(e, 0, N));
            chk("R3 lim on count", on_l, map_on(e, LMIN, LMAX));
            chk("R3 lim off count", off_l, N - map_on(e, LMIN, LMAX));
            measure(hi, lo);
            chk("R4 high span", hi, map_on(e, 0, N) * P);
            chk("R4 low span", lo, (N - map_on(e, 0, N)) * P);
        end
    endtask

    task automatic t_shadow();
        int w, hi, lo, i;
        strobe(128);
        wait_load(w);
        wait_rise();
        hi = 1;
        i  = 0;
        while (hi < 2000) begin
            @(negedge clk);
            i++;
            if (i == 5) begin err_in = 8'd200; err_valid = 1'b1; end
            if (i == 6) err_valid = 1'b0;
            if (i == 8) chk("R6 on_cnt held after strobe", on_c, 20);
            if (!pwm) break;
            hi++;
        end
        chk("R6 current high unchanged", hi, 20 * P);
        lo = 0;
        while (!pwm && lo < 2000) begin lo++; @(negedge clk); end
        chk("R6 current low unchanged", lo, 20 * P);
        chk("R7 new pair at boundary", on_c, 31);
        hi = 0;
        while (pwm && hi < 2000) begin hi++; @(negedge clk); end
        chk("R6 next high uses new value", hi, 31 * P);
    endtask

    task automatic t_zero();
        int w, highs = 0;
        strobe(0);
        wait_load(w);
        chk("R8 on count zero", on_c, 0);
        chk("R3 lim floor", on_l, LMIN);
        repeat (3 * N * P) begin @(negedge clk); if (pwm) highs++; end
        chk("R8 no high tick", highs, 0);
    endtask

    task automatic t_full();
        int w, hi, lo, lows = 0;
        strobe(255);
        wait_load(w);
        chk("R9 on count full", on_c, N);
        chk("R9 off count zero", off_c, 0);
        chk("R3 lim ceiling", on_l, LMAX);
        repeat (3 * N * P) begin @(negedge clk); if (!pwm) lows++; end
        chk("R9 no low tick", lows, 0);
        strobe(128);
        measure(hi, lo);
        chk("R4 recover high", hi, 20 * P);
        chk("R4 recover low", lo, 20 * P);
    endtask

    task automatic t_collide();
        int w, hi;
        strobe(64);
        wait_load(w);
        wait_rise();
        for (int i = 1; i <= N * P; i++) begin
            @(negedge clk);
            if (i == 40)        begin err_in = 8'd200; err_valid = 1'b1; end
            if (i == 41)        err_valid = 1'b0;
            if (i == N * P - 1) begin err_in = 8'd128; err_valid = 1'b1; end
            if (i == N * P)     err_valid = 1'b0;
        end
        chk("R10 load at boundary", ld, 1);
        chk("R10 pending value used", on_c, 31);
        chk("R10 rise at boundary", pwm, 1);
        hi = 0;
        while (pwm && hi < 2000) begin hi++; @(negedge clk); end
        chk("R10 high of pending value", hi, 31 * P);
        wait_load(w);
        chk("R10 later value next period", on_c, 20);
    endtask

    initial begin
        t_reset();
        t_first();
        t_values();
        t_shadow();
        t_zero();
        t_full();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule